// File: doc/BRIEF.md
# Addressed Serial Frame Interface for a Segment Display Controller

This block is the serial slave of a segment display controller. A host drives a chip-enable, a serial clock and a data line. While chip-enable is low the host shifts in an 8-bit device address, least significant bit first. When chip-enable rises, that address picks the transfer direction. A write transfer delivers a 56-bit frame. A trailing 2-bit selector routes the frame into one of four sections of a 164-bit segment register, and section 0 also carries eight control bits. A read transfer shifts the 30 key-matrix bits out, followed by a sleep acknowledge bit.

All pins are oversampled by the system clock and reduced to edge strobes. A write frame is committed on the falling edge of chip-enable, and only when exactly 56 data bits arrived. The key scanner receives a one-cycle strobe each time a read transfer closes. The serial clock may idle low or high between transfers.

Top module: `lcd_serial_if`

## Requirements
- R1: After reset the segment register output is all zero, every control output is 0 except the segment-off bit which is 1, sleep is 0, and the data output is released (sdo_oe low).
- R2: The address is the last 8 bits sampled on rising SCK while CE is low, the first bit being bit 0. 8'h42 opens a write, 8'h43 opens a read. Any other address leaves the registers unchanged and keeps sdo_oe low for the whole transfer.
- R3: In a write, data bits are sampled on rising SCK while CE is high. The frame commits on the CE fall only if exactly 56 bits were received. A 55-bit or 57-bit frame changes nothing.
- R4: Frame bit positions count from 0 for the first bit sent. Bits 54 and 55 form the section selector, and bit 54 is its most significant bit. For selector 0, frame bits 0..43 load segment outputs 0..43.
- R5: For selector s in 1..3, frame bits 0..39 load segment outputs 44+40*(s-1) .. 83+40*(s-1). All other sections keep their contents.
- R6: For selector 0, frame bits 46..53 load, in this order, sleep_mode_o[0], sleep_mode_o[1], key_mode_o[0], key_mode_o[1], port_mode_o[0], port_mode_o[1], seg_off_o and half_bias_o.
- R7: sleep_o is 1 while either sleep_mode_o bit is 1. Frames with selector 1..3 never change the control outputs, whatever they carry in bits 40..53. Only a selector-0 frame with both sleep bits 0 clears sleep.
- R8: In a read, sdo_oe is high while CE is high, and sdo shows key_i[0] from the CE rise. Each falling SCK that follows a rising SCK in the same transfer advances sdo by one bit: key_i[0..29], then the sleep state.
- R9: With SCK idling high, the falling SCK that comes before the first rising SCK of a read does not advance sdo.
- R10: key_read_done pulses high for exactly one cycle when CE falls at the end of a read. It never pulses for write or unrecognised transfers.
- R11: sdo_oe stays low during the address phase and throughout write transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable: low during the address phase, high during the frame |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| key_i | input | 30 | Key matrix bits from the scanner, bit 0 sent first |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | High while sdo is being driven (read transfer active) |
| key_read_done | output | 1 | One-cycle strobe when a read transfer closes |
| disp_o | output | 164 | Segment register contents |
| sleep_mode_o | output | 2 | Sleep control pair |
| key_mode_o | output | 2 | Key-scan / segment pin sharing selection |
| port_mode_o | output | 2 | Segment / general-purpose port selection |
| seg_off_o | output | 1 | Segment blanking control |
| half_bias_o | output | 1 | Drive bias selection |
| sleep_o | output | 1 | Sleep state, also returned as the last read bit |

## Verification
The assertions assume that the host never moves CE and SCK within the same oversampling cycle. They also assume that each pin level is held for at least three system clocks, so that every serial edge becomes exactly one strobe. The bench keeps every serial phase four clocks long and changes CE only while SCK is at its idle level. It also sets sdi a full phase before the SCK edge that samples it.

// File: rtl/lcdsif_pkg.sv
package lcdsif_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2
  } xfer_e;

  // first bit of a section inside the flat segment register
  function automatic int sec_base(input int s, input int first_len, input int rest_len);
    return (s == 0) ? 0 : first_len + (s - 1) * rest_len;
  endfunction

  // number of segment bits a section carries
  function automatic int sec_len(input int s, input int first_len, input int rest_len);
    return (s == 0) ? first_len : rest_len;
  endfunction

  function automatic xfer_e decode_addr(input logic [7:0] a, input logic [7:0] wr,
                                        input logic [7:0] rd);
    if (a == wr) return XF_WRITE;
    if (a == rd) return XF_READ;
    return XF_IDLE;
  endfunction

endpackage

// File: rtl/sif_pin_sync.sv
module sif_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sck,
  input  logic sdi,
  output logic ce_lvl,
  output logic ce_rise,
  output logic ce_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic ce_q, ce_qq, sck_q, sck_qq, sdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      ce_qq  <= 1'b0;
      sck_q  <= 1'b0;
      sck_qq <= 1'b0;
      sdi_q  <= 1'b0;
    end else begin
      ce_q   <= ce;
      ce_qq  <= ce_q;
      sck_q  <= sck;
      sck_qq <= sck_q;
      sdi_q  <= sdi;
    end
  end

  assign ce_lvl   = ce_q;
  assign ce_rise  = ce_q & ~ce_qq;
  assign ce_fall  = ~ce_q & ce_qq;
  assign sck_rise = sck_q & ~sck_qq;
  assign sck_fall = ~sck_q & sck_qq;
  assign sdi_s    = sdi_q;
endmodule

// File: rtl/sif_frame_rx.sv
module sif_frame_rx
  import lcdsif_pkg::*;
#(
  parameter int          FRAME_BITS = 56,
  parameter logic [7:0]  WR_ADDR    = 8'h42,
  parameter logic [7:0]  RD_ADDR    = 8'h43,
  localparam int         CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_lvl,
  input  logic                  ce_rise,
  input  logic                  ce_fall,
  input  logic                  sck_rise,
  input  logic                  sdi_s,
  output xfer_e                 mode,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  wr_commit,
  output logic                  rd_done
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [7:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= XF_IDLE;
      addr_q  <= '0;
      frame   <= '0;
      bit_cnt <= '0;
    end else if (ce_rise) begin
      mode    <= decode_addr(addr_q, WR_ADDR, RD_ADDR);
      bit_cnt <= '0;
    end else if (ce_fall) begin
      mode <= XF_IDLE;
    end else if (sck_rise) begin
      if (ce_lvl) begin
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (mode == XF_WRITE) frame <= {sdi_s, frame[FRAME_BITS-1:1]};
      end else begin
        addr_q <= {sdi_s, addr_q[7:1]};
      end
    end
  end

  assign wr_commit = ce_fall && (mode == XF_WRITE) && (bit_cnt == CNT_FULL);
  assign rd_done   = ce_fall && (mode == XF_READ);
endmodule

// File: rtl/sif_reg_bank.sv
module sif_reg_bank
  import lcdsif_pkg::*;
#(
  parameter int  FRAME_BITS = 56,
  parameter int  SEC0_BITS  = 44,
  parameter int  SEC_BITS   = 40,
  parameter int  NUM_SEC    = 4,
  localparam int DISP_BITS  = SEC0_BITS + (NUM_SEC - 1) * SEC_BITS,
  localparam int SEL_W      = $clog2(NUM_SEC),
  localparam int SEL_POS    = FRAME_BITS - SEL_W,
  localparam int CTRL_POS   = SEC0_BITS + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] frame,
  output logic [DISP_BITS-1:0]  disp_o,
  output logic [7:0]            ctrl_o
);
  logic [SEL_W-1:0] sel;

  // first selector bit sent is the most significant one
  always_comb begin
    for (int j = 0; j < SEL_W; j++) sel[SEL_W-1-j] = frame[SEL_POS+j];
  end

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    localparam int BASE = sec_base(s, SEC0_BITS, SEC_BITS);
    localparam int LEN  = sec_len(s, SEC0_BITS, SEC_BITS);
    logic [LEN-1:0] seg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seg_q <= '0;
      else if (commit && sel == SEL_W'(s))        seg_q <= frame[LEN-1:0];
    end

    assign disp_o[BASE +: LEN] = seg_q;
  end

  // control byte: S0 S1 K0 K1 P0 P1 SC DR at bit 0..7
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ctrl_o <= 8'h40;
    else if (commit && sel == '0)     ctrl_o <= frame[CTRL_POS +: 8];
  end
endmodule

// File: rtl/sif_key_tx.sv
module sif_key_tx #(
  parameter int KEYS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [KEYS-1:0] key_i,
  input  logic            sa_i,
  output logic            sdo
);
  logic [KEYS:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= {sa_i, key_i};
    else if (shift) sreg <= {1'b0, sreg[KEYS:1]};
  end

  assign sdo = sreg[0];
endmodule

// File: rtl/lcd_serial_if.sv
module lcd_serial_if
  import lcdsif_pkg::*;
#(
  parameter int          KEYS       = 30,
  parameter int          FRAME_BITS = 56,
  parameter int          SEC0_BITS  = 44,
  parameter int          SEC_BITS   = 40,
  parameter int          NUM_SEC    = 4,
  parameter logic [7:0]  WR_ADDR    = 8'h42,
  parameter logic [7:0]  RD_ADDR    = 8'h43,
  localparam int         DISP_BITS  = SEC0_BITS + (NUM_SEC - 1) * SEC_BITS,
  localparam int         CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic [KEYS-1:0]      key_i,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic                 key_read_done,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [1:0]           sleep_mode_o,
  output logic [1:0]           key_mode_o,
  output logic [1:0]           port_mode_o,
  output logic                 seg_off_o,
  output logic                 half_bias_o,
  output logic                 sleep_o
);
  logic ce_lvl, ce_rise, ce_fall, sck_rise, sck_fall, sdi_s;
  xfer_e                 mode;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  wr_commit;
  logic [7:0]            ctrl;
  logic                  key_shift;

  sif_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi),
    .ce_lvl(ce_lvl), .ce_rise(ce_rise), .ce_fall(ce_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  sif_frame_rx #(.FRAME_BITS(FRAME_BITS), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .ce_lvl(ce_lvl), .ce_rise(ce_rise), .ce_fall(ce_fall),
    .sck_rise(sck_rise), .sdi_s(sdi_s), .mode(mode), .frame(frame),
    .bit_cnt(bit_cnt), .wr_commit(wr_commit), .rd_done(key_read_done)
  );

  sif_reg_bank #(.FRAME_BITS(FRAME_BITS), .SEC0_BITS(SEC0_BITS), .SEC_BITS(SEC_BITS),
                 .NUM_SEC(NUM_SEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit), .frame(frame),
    .disp_o(disp_o), .ctrl_o(ctrl)
  );

  // a falling SCK advances only after a rising SCK of the same read
  assign key_shift = sck_fall && (mode == XF_READ) && (bit_cnt != '0);

  sif_key_tx #(.KEYS(KEYS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ce_rise), .shift(key_shift),
    .key_i(key_i), .sa_i(sleep_o), .sdo(sdo)
  );

  assign sdo_oe       = (mode == XF_READ);
  assign sleep_mode_o = ctrl[1:0];
  assign key_mode_o   = ctrl[3:2];
  assign port_mode_o  = ctrl[5:4];
  assign seg_off_o    = ctrl[6];
  assign half_bias_o  = ctrl[7];
  assign sleep_o      = |ctrl[1:0];
endmodule

// File: rtl/lcd_serial_if_chk.sv
module lcd_serial_if_chk #(
  parameter int DISP_BITS = 164
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ce_lvl,
  input logic                 ce_fall,
  input logic                 sck_fall,
  input logic                 wr_commit,
  input logic                 sdo,
  input logic                 sdo_oe,
  input logic                 key_read_done,
  input logic [DISP_BITS-1:0] disp_o,
  input logic                 sleep_o
);
  assert_so_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lvl && !ce_fall) |-> !sdo_oe);

  assert_disp_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_o) |-> $past(wr_commit));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_read_done |=> !key_read_done);

  assert_sleep_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> $past(wr_commit));

  assert_sdo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sck_fall)) |-> $stable(sdo));
endmodule

bind lcd_serial_if lcd_serial_if_chk #(.DISP_BITS(DISP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_lvl(ce_lvl), .ce_fall(ce_fall), .sck_fall(sck_fall),
  .wr_commit(wr_commit), .sdo(sdo), .sdo_oe(sdo_oe), .key_read_done(key_read_done),
  .disp_o(disp_o), .sleep_o(sleep_o)
);

// File: tb/lcd_serial_if_test.sv
module lcd_serial_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [29:0]  key_i = '0;
  logic sdo, sdo_oe, key_read_done, seg_off_o, half_bias_o, sleep_o;
  logic [163:0] disp_o;
  logic [1:0]   sleep_mode_o, key_mode_o, port_mode_o;

  int n_chk = 0, n_fail = 0;
  int oe_cnt = 0, done_cnt = 0;
  logic idle_hi = 1'b0;
  logic [163:0] exp_disp = '0;
  logic [7:0]   exp_ctrl = 8'h40;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_serial_if uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi), .key_i(key_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .key_read_done(key_read_done), .disp_o(disp_o),
    .sleep_mode_o(sleep_mode_o), .key_mode_o(key_mode_o), .port_mode_o(port_mode_o),
    .seg_off_o(seg_off_o), .half_bias_o(half_bias_o), .sleep_o(sleep_o)
  );

  always @(posedge clk) begin
    if (sdo_oe) oe_cnt <= oe_cnt + 1;
    if (key_read_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string req, input logic [163:0] act, input logic [163:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b);
    if (idle_hi) begin
      sck = 1'b0; sdi = b; wait_h(); sck = 1'b1; wait_h();
    end else begin
      sdi = b; wait_h(); sck = 1'b1; wait_h(); sck = 1'b0;
    end
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 0; i < 8; i++) tx_bit(a[i]);
    wait_h(); ce = 1'b1; wait_h();
  endtask

  task automatic close_frame();
    wait_h(); ce = 1'b0; wait_h(); wait_h();
  endtask

  function automatic logic [55:0] mk_frame(input logic [1:0] sel, input logic [43:0] pay,
                                           input logic [7:0] ctl);
    logic [55:0] f = '0;
    for (int i = 0; i < 44; i++) if (sel == 2'd0 || i < 40) f[i] = pay[i];
    if (sel == 2'd0) for (int j = 0; j < 8; j++) f[46+j] = ctl[j];
    f[54] = sel[1];
    f[55] = sel[0];
    return f;
  endfunction

  task automatic write_raw(input logic [7:0] a, input logic [55:0] f, input int nbits);
    send_addr(a);
    for (int i = 0; i < nbits; i++) tx_bit(i < 56 ? f[i] : 1'b1);
    close_frame();
  endtask

  function automatic logic [163:0] ctrl_now();
    return 164'({half_bias_o, seg_off_o, port_mode_o, key_mode_o, sleep_mode_o});
  endfunction

  // write one section and update the model
  task automatic t_write(input string req, input logic [1:0] sel, input logic [43:0] pay,
                         input logic [7:0] ctl);
    int oe0 = oe_cnt, d0 = done_cnt;
    write_raw(8'h42, mk_frame(sel, pay, ctl), 56);
    if (sel == 2'd0) begin
      exp_disp[43:0] = pay;
      exp_ctrl = ctl;
    end else begin
      exp_disp[44 + 40*(int'(sel)-1) +: 40] = pay[39:0];
    end
    chk(req, disp_o, exp_disp);
    chk("R6 control outputs", ctrl_now(), 164'(exp_ctrl));
    chk("R7 sleep state", 164'(sleep_o), 164'(|exp_ctrl[1:0]));
    chk("R11 sdo released in write", 164'(oe_cnt - oe0), 164'(0));
    chk("R10 no done strobe after write", 164'(done_cnt - d0), 164'(0));
  endtask

  task automatic t_read(input string req, input logic [29:0] keys);
    logic [30:0] got;
    int d0 = done_cnt, oe_miss = 0;
    key_i = keys;
    send_addr(8'h43);
    for (int i = 0; i < 31; i++) begin
      if (idle_hi) begin
        sck = 1'b0; wait_h(); got[i] = sdo; if (!sdo_oe) oe_miss++; sck = 1'b1; wait_h();
      end else begin
        got[i] = sdo; if (!sdo_oe) oe_miss++; sck = 1'b1; wait_h(); sck = 1'b0; wait_h();
      end
    end
    close_frame();
    chk(req, 164'(got), 164'({|exp_ctrl[1:0], keys}));
    chk("R8 sdo_oe high through read", 164'(oe_miss), 164'(0));
    chk("R10 one done strobe per read", 164'(done_cnt - d0), 164'(1));
  endtask

  task automatic t_reset();
    chk("R1 segment register", disp_o, '0);
    chk("R1 control outputs", ctrl_now(), 164'(8'h40));
    chk("R1 sleep", 164'(sleep_o), 164'(0));
    chk("R1 sdo released", 164'(sdo_oe), 164'(0));
  endtask

  task automatic t_bad_length();
    write_raw(8'h42, mk_frame(2'd1, 44'h0_5555_AAAA_55, 8'h00), 55);
    chk("R3 55-bit frame dropped", disp_o, exp_disp);
    write_raw(8'h42, mk_frame(2'd2, 44'h0_1111_2222_33, 8'h00), 57);
    chk("R3 57-bit frame dropped", disp_o, exp_disp);
  endtask

  task automatic t_unknown_addr();
    int oe0 = oe_cnt, d0 = done_cnt;
    write_raw(8'h44, mk_frame(2'd3, 44'h0_DEAD_BEEF_01, 8'h00), 56);
    write_raw(8'hC2, mk_frame(2'd0, 44'hFFF_FFFF_FFFF, 8'h00), 56);
    chk("R2 unknown address ignored", disp_o, exp_disp);
    chk("R2 unknown address control kept", ctrl_now(), 164'(exp_ctrl));
    chk("R2 sdo released for unknown address", 164'(oe_cnt - oe0), 164'(0));
    chk("R10 no done strobe for unknown address", 164'(done_cnt - d0), 164'(0));
  endtask

  task automatic t_upper_fill();
    logic [55:0] f = mk_frame(2'd2, 44'h0_FEDC_BA98_76, 8'h00);
    for (int i = 40; i < 54; i++) f[i] = 1'b1;
    write_raw(8'h42, f, 56);
    exp_disp[84 +: 40] = 40'hFE_DCBA_9876;
    chk("R5 section 2 with filled upper bits", disp_o, exp_disp);
    chk("R7 section 2 leaves control", ctrl_now(), 164'(exp_ctrl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write("R4 section 0 load", 2'd0, 44'hA5C_3F01_96E2, 8'b1001_0110);
    t_write("R5 section 1 load", 2'd1, 44'h0_1234_5678_9A, 8'h00);
    t_write("R5 section 3 load", 2'd3, 44'h0_0FF0_0FF0_0F, 8'h00);
    t_upper_fill();
    t_read("R8 read keys and sleep ack", 30'h2BCD_1234);
    t_bad_length();
    t_unknown_addr();
    t_write("R7 sleep cleared by zero pair", 2'd0, 44'h3C3_C3C3_C3C3, 8'b0110_1000);
    t_read("R8 read with sleep clear", 30'h1555_AAAA);
    idle_hi = 1'b1;
    sck = 1'b1;
    wait_h();
    t_read("R9 read with SCK idling high", 30'h0F0F_3C3C);
    t_write("R9 section 1 with SCK idling high", 2'd1, 44'h0_8765_4321_0F, 8'h00);
    t_write("R6 section 0 with SCK idling high", 2'd0, 44'h001_0203_0405, 8'b1111_1101);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule